// File: doc/BRIEF.md
# Performance Monitor Control Unit

This block keeps the 32-bit control word of a performance monitor and runs the counters that the word governs: one free-running cycle counter and a bank of event counters, one for each event pulse input. Software writes the word through a simple write port and reads it back at once. Two of its bits are self-clearing strobes that zero the counters. A debug-enable input decides, together with the control bits, whether events are counted, whether they appear on an exported event bus, and whether the cycle counter may keep running.

Every counter needs the global run bit. A divider bit slows the cycle counter to one step every 64 clocks. When debug is disabled, the event counters freeze and the export bus goes idle. The cycle counter then runs or stops according to a debug-stop bit. When debug is enabled, that bit has no effect. The event counters and the export path do not depend on the divider.

Top module: `perfmon_ctrl_unit`

## Requirements
- R1: After reset the readback is 0x0000_2000, both counter outputs are zero and the export bus is zero.
- R2: The readback has the counter count (4) in bits [15:11]. Bits [31:16], [10:6], 2 and 1 read as zero. Bits 0 (run), 3 (divide), 4 (export) and 5 (debug-stop) read back the value last written to them. Writes to the zero bits and to [15:11] are ignored, so writing all ones reads back 0x0000_2039.
- R3: While bit 0 is 0, neither the cycle counter nor any event counter changes, except through a clear strobe.
- R4: With bit 0 = 1, bit 3 = 0 and debug enabled, the cycle counter gains one per clock. Event counter i gains one for each clock in which event input i is high.
- R5: Writing 1 to bit 1 zeroes every event counter on the next cycle, even if an event arrives in the write cycle.
- R6: Writing 1 to bit 2 zeroes the cycle counter on the next cycle, even if it would have advanced in the write cycle.
- R7: With bit 3 = 1, the cycle counter advances once every 64 running clocks, counted from reset or from the last cycle-counter clear. The event counters still count every event.
- R8: With debug enabled and bit 4 = 1, the export bus shows the event inputs one clock later. With bit 4 = 0, the export bus is zero.
- R9: With debug disabled, the event counters hold and the export bus is zero, whatever bit 4 holds.
- R10: With debug disabled, the cycle counter runs if bit 5 = 0 and holds if bit 5 = 1. With debug enabled, bit 5 has no effect.
- R11: Counters are CNT_W bits wide (32 by default) and wrap from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Data written to the control word |
| rdData | output | 32 | Current control word readback |
| dbgEn | input | 1 | Non-invasive debug enable |
| evtIn | input | NUM_EVT | Event pulses, one per event counter |
| evtBus | output | NUM_EVT | Exported events, registered |
| cycCount | output | CNT_W | Cycle counter value |
| evtCount | output | NUM_EVT*CNT_W | Event counter values, counter i in slice i |

## Verification
Two functions can fall in the same cycle. A clear strobe can arrive in the same cycle as an increment, and a control write can land while debug is disabled. The bench provokes the first by writing the clear bits while every event input is high and the run bit is set, and expects zero on the next cycle rather than one. It provokes the second by setting the debug-stop bit while debug is low, and expects one last cycle step, taken under the old setting, before the counter freezes.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int CTRL_W = 32;
  // bit positions inside the control word (decoded by software)
  localparam int RUN_BIT      = 0;
  localparam int EVCLR_BIT    = 1;
  localparam int CYCLR_BIT    = 2;
  localparam int DIV_BIT      = 3;
  localparam int EXPORT_BIT   = 4;
  localparam int DBGSTOP_BIT  = 5;
  localparam int NUMFIELD_LO  = 11;
  localparam int NUMFIELD_W   = 5;

  typedef struct packed {
    logic evtStep;   // event counters may count this cycle
    logic cycStep;   // cycle counter advances this cycle
    logic evtClear;  // zero all event counters
    logic cycClear;  // zero the cycle counter
    logic exportOn;  // forward events to the export bus
  } ctrlStrobe_t;
endpackage

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      value <= '0;
    else if (clr)   value <= '0;          // clear beats increment
    else if (inc)   value <= value + W'(1); // wraps naturally
  end
endmodule

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
  import perfmon_pkg::*;
#(
  parameter int NUM_EVT  = 4,
  parameter int DIV_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              dbgEn,
  output logic [CTRL_W-1:0] rdData,
  output ctrlStrobe_t       strobe
);
  localparam logic [NUMFIELD_W-1:0] NUM_FIELD = NUMFIELD_W'(NUM_EVT);

  logic runEn, divSel, exportEn, dbgStop;
  logic [DIV_LOG2-1:0] preCnt;
  logic cycRun, divTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn    <= 1'b0;
      divSel   <= 1'b0;
      exportEn <= 1'b0;
      dbgStop  <= 1'b0;
    end else if (wrEn) begin
      runEn    <= wrData[RUN_BIT];
      divSel   <= wrData[DIV_BIT];
      exportEn <= wrData[EXPORT_BIT];
      dbgStop  <= wrData[DBGSTOP_BIT];
    end
  end

  // cycle counting allowed: run bit, and debug enabled or no debug stop
  assign cycRun  = runEn & (dbgEn | ~dbgStop);
  assign divTick = divSel ? (&preCnt) : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               preCnt <= '0;
    else if (wrEn && wrData[CYCLR_BIT])      preCnt <= '0;
    else if (cycRun)                         preCnt <= preCnt + DIV_LOG2'(1);
  end

  always_comb begin
    strobe.evtStep  = runEn & dbgEn;
    strobe.cycStep  = cycRun & divTick;
    strobe.evtClear = wrEn & wrData[EVCLR_BIT];
    strobe.cycClear = wrEn & wrData[CYCLR_BIT];
    strobe.exportOn = dbgEn & exportEn;
  end

  always_comb begin
    rdData = '0;
    rdData[RUN_BIT]     = runEn;
    rdData[DIV_BIT]     = divSel;
    rdData[EXPORT_BIT]  = exportEn;
    rdData[DBGSTOP_BIT] = dbgStop;
    rdData[NUMFIELD_LO +: NUMFIELD_W] = NUM_FIELD;
  end
endmodule

// File: rtl/perfmon_datapath.sv
module perfmon_datapath
  import perfmon_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int CNT_W   = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic [NUM_EVT-1:0]       evtIn,
  output logic [NUM_EVT-1:0]       evtBus,
  output logic [CNT_W-1:0]         cycCount,
  output logic [NUM_EVT*CNT_W-1:0] evtCount
);
  perfmon_counter #(.W(CNT_W)) cycCtr (
    .clk(clk), .rstN(rstN), .clr(strobe.cycClear),
    .inc(strobe.cycStep), .value(cycCount)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    perfmon_counter #(.W(CNT_W)) evtCtr (
      .clk(clk), .rstN(rstN), .clr(strobe.evtClear),
      .inc(strobe.evtStep & evtIn[i]),
      .value(evtCount[i*CNT_W +: CNT_W])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                evtBus <= '0;
    else if (strobe.exportOn) evtBus <= evtIn;
    else                      evtBus <= '0;
  end
endmodule

// File: rtl/perfmon_ctrl_unit.sv
module perfmon_ctrl_unit
  import perfmon_pkg::*;
#(
  parameter int NUM_EVT  = 4,
  parameter int CNT_W    = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [31:0]              wrData,
  output logic [31:0]              rdData,
  input  logic                     dbgEn,
  input  logic [NUM_EVT-1:0]       evtIn,
  output logic [NUM_EVT-1:0]       evtBus,
  output logic [CNT_W-1:0]         cycCount,
  output logic [NUM_EVT*CNT_W-1:0] evtCount
);
  ctrlStrobe_t strobe;

  perfmon_ctrl #(.NUM_EVT(NUM_EVT), .DIV_LOG2(DIV_LOG2)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .dbgEn(dbgEn), .rdData(rdData), .strobe(strobe)
  );

  perfmon_datapath #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evtIn(evtIn),
    .evtBus(evtBus), .cycCount(cycCount), .evtCount(evtCount)
  );
endmodule

// File: rtl/perfmon_ctrl_unit_checker.sv
module perfmon_ctrl_unit_checker #(
  parameter int NUM_EVT = 4,
  parameter int CNT_W   = 32
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic [31:0]              wrData,
  input logic [31:0]              rdData,
  input logic                     dbgEn,
  input logic [NUM_EVT-1:0]       evtIn,
  input logic [NUM_EVT-1:0]       evtBus,
  input logic [CNT_W-1:0]         cycCount,
  input logic [NUM_EVT*CNT_W-1:0] evtCount
);
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!rdData[0] && !wrEn) |=> ($stable(cycCount) && $stable(evtCount)));

  p_cyc_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[0] && dbgEn && !rdData[3] && !wrEn) |=> (cycCount == $past(cycCount) + CNT_W'(1)));

  p_evt_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[1]) |=> (evtCount == '0));

  p_cyc_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[2]) |=> (cycCount == '0));

  p_export_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dbgEn && rdData[4]) |=> (evtBus == $past(evtIn)));

  p_export_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!rdData[4]) |=> (evtBus == '0));

  p_nodebug_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!dbgEn && !wrEn) |=> ((evtBus == '0) && $stable(evtCount)));

  p_dbgstop_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!dbgEn && rdData[5] && !wrEn) |=> $stable(cycCount));
endmodule

bind perfmon_ctrl_unit perfmon_ctrl_unit_checker #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .dbgEn(dbgEn), .evtIn(evtIn), .evtBus(evtBus), .cycCount(cycCount),
  .evtCount(evtCount)
);

// File: tb/perfmon_ctrl_unit_test.sv
module perfmon_ctrl_unit_test;
  localparam int NE = 4;
  localparam int CW = 32;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic dbgEn = 1'b1;
  logic [NE-1:0] evtIn = '0;
  logic [NE-1:0] evtBus;
  logic [CW-1:0] cycCount;
  logic [NE*CW-1:0] evtCount;

  logic nWrEn = 1'b0;
  logic [31:0] nWrData = '0;
  logic [31:0] nRdData;
  logic [NE-1:0] nEvtIn = '0;
  logic [NE-1:0] nEvtBus;
  logic [NW-1:0] nCyc;
  logic [NE*NW-1:0] nEvt;

  int checks = 0;
  int fails = 0;
  logic [31:0] snapC, snapE;

  always #5 clk = ~clk;

  perfmon_ctrl_unit uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .dbgEn(dbgEn), .evtIn(evtIn), .evtBus(evtBus), .cycCount(cycCount),
    .evtCount(evtCount)
  );

  perfmon_ctrl_unit #(.CNT_W(NW)) uutNarrow (
    .clk(clk), .rstN(rstN), .wrEn(nWrEn), .wrData(nWrData), .rdData(nRdData),
    .dbgEn(dbgEn), .evtIn(nEvtIn), .evtBus(nEvtBus), .cycCount(nCyc),
    .evtCount(nEvt)
  );

  // write data, expected readback
  localparam logic [63:0] VEC [6] = '{
    {32'hFFFF_FFFF, 32'h0000_2039},
    {32'h0000_0000, 32'h0000_2000},
    {32'h0000_0006, 32'h0000_2000},
    {32'h0000_0011, 32'h0000_2011},
    {32'hFFFF_F828, 32'h0000_2028},
    {32'h0000_0000, 32'h0000_2000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(logic [31:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  function automatic logic [31:0] ev(int i);
    return evtCount[i*CW +: CW];
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    check("R1 readback", rdData, 32'h0000_2000);
    check("R1 cycle", cycCount, 0);
    check("R1 event0", ev(0), 0);
    check("R1 bus", 32'(evtBus), 0);

    // R2 register map via vector table
    for (int k = 0; k < 6; k++) begin
      writeReg(VEC[k][63:32]);
      check("R2 readback", rdData, VEC[k][31:0]);
    end

    // R5/R6 basic clear with run off
    writeReg(32'h6);
    check("R6 cycle cleared", cycCount, 0);
    check("R5 events cleared", evtCount[31:0] | evtCount[127:96], 0);

    // R3 no counting without run bit
    evtIn = 4'hF; dbgEn = 1'b1;
    step(10);
    check("R3 cycle held", cycCount, 0);
    check("R3 event held", ev(2), 0);

    // R4 counting
    writeReg(32'h1);
    check("R4 start", cycCount, 0);
    evtIn = 4'b0101; step(5);
    evtIn = 4'b0011; step(3);
    evtIn = 4'b0000;
    check("R4 cycle", cycCount, 8);
    check("R4 event0", ev(0), 8);
    check("R4 event1", ev(1), 3);
    check("R4 event2", ev(2), 5);
    check("R4 event3", ev(3), 0);

    // R5 clear beats concurrent event
    evtIn = 4'hF;
    writeReg(32'h3);
    check("R5 event0 zero", ev(0), 0);
    check("R5 event3 zero", ev(3), 0);
    check("R5 cycle ran", cycCount, 9);
    step(1);
    check("R5 event1 resumes", ev(1), 1);

    // R6 clear beats concurrent cycle step
    writeReg(32'h5);
    check("R6 cycle zero", cycCount, 0);
    check("R6 events untouched", ev(0), 2);

    // R8 export
    evtIn = 4'b1010; step(1);
    check("R8 bus idle", 32'(evtBus), 0);
    writeReg(32'h11);
    check("R8 bus idle on write", 32'(evtBus), 0);
    step(1);
    check("R8 bus follows", 32'(evtBus), 32'hA);
    evtIn = 4'b0110; step(1);
    check("R8 bus follows 2", 32'(evtBus), 32'h6);

    // R9/R10 debug disabled
    evtIn = 4'hF;
    snapC = cycCount; snapE = ev(1);
    dbgEn = 1'b0;
    step(5);
    check("R9 bus idle", 32'(evtBus), 0);
    check("R9 events held", ev(1), snapE);
    check("R10 cycle runs with stop clear", cycCount, snapC + 5);
    writeReg(32'h31);
    check("R10 last step", cycCount, snapC + 6);
    step(5);
    check("R10 cycle stopped", cycCount, snapC + 6);
    dbgEn = 1'b1;
    step(3);
    check("R10 stop ignored when debug on", cycCount, snapC + 9);
    check("R9 events resume", ev(1), snapE + 3);

    // R7 divider
    evtIn = 4'b0001;
    doReset();
    writeReg(32'h9);
    step(63);
    check("R7 before tick", cycCount, 0);
    step(1);
    check("R7 first tick", cycCount, 1);
    step(64);
    check("R7 second tick", cycCount, 2);
    check("R7 events undivided", ev(0), 128);

    // R11 wrap on narrow instance
    nEvtIn = 4'b0001;
    nWrEn = 1'b1; nWrData = 32'h1;
    @(negedge clk);
    nWrEn = 1'b0; nWrData = '0;
    step(15);
    check("R11 cycle at max", 32'(nCyc), 15);
    check("R11 event at max", 32'(nEvt[NW-1:0]), 15);
    step(1);
    check("R11 cycle wrapped", 32'(nCyc), 0);
    check("R11 event wrapped", 32'(nEvt[NW-1:0]), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule